// File: doc/BRIEF.md
# Colour Palette Lookup Table with Sequenced Register Writes

This block holds a colour lookup table of 256 entries. Each entry is a 24-bit colour made of an 8-bit red, an 8-bit green and an 8-bit blue part. Software loads the table through two word-aligned registers on a 32-bit register bus. It first writes a starting entry number to the pointer register. It then writes colour parts to the colour register. Each colour write fills the next part of the pointed-to entry, in the order red, green, blue. After the blue part the pointer moves on to the next entry. A whole run of entries can therefore be loaded with one pointer write followed by a stream of colour writes. Only the most significant byte of each bus word carries information.

A pixel pipeline reads the table through a separate lookup port. That port gives the colour of any entry with no clock delay. The block also raises a one-cycle pulse after every colour-part write, so a display engine knows the table has changed and can redraw.

Top module: `pal_dac`

## Requirements
- R1: A write to byte offset 0x0 loads the entry pointer from data bits 31:24 and sets the part sequencer back to the red step.
- R2: Writes to byte offset 0x4 store data bits 31:24 into the red, green and blue part of the pointed-to entry on the first, second and third write. The lookup result is packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: The write that stores the blue part also increments the entry pointer modulo 256, so 255 is followed by 0, and returns the sequencer to red.
- R4: Every bus read returns zero, whatever the offset.
- R5: After reset, entries 0 to 254 are 0x000000 and entry 255 is 0xFFFFFF. The pointer is 0 and the sequencer is at the red step.
- R6: Writes to any offset other than 0x0 and 0x4 (0x8, 0xC and unaligned offsets) change neither the table, the pointer nor the sequencer. Data bits 23:0 never affect the result.
- R7: The lookup output is combinational on the lookup index. During a cycle in which the same entry is being written, it shows the old colour. It shows the new colour once the write's clock edge has passed.
- R8: The change pulse is high for exactly the one cycle after each colour-part write and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the 16-byte register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| lu_idx | input | 8 | Lookup entry number |
| lu_rgb | output | 24 | Colour of the looked-up entry, {red, green, blue} |
| pal_changed | output | 1 | One-cycle pulse after a colour-part write |

## Verification
A register write takes effect at the clock edge that samples it. Pointer, sequencer and table contents therefore show the new values right after that edge, and the lookup output reflects them without further delay. The change pulse is due in the cycle following the write edge, and read data is zero in every cycle. The bench drives inputs 2 ns after a rising edge. It checks the lookup output 1 ns later, which is still the old value before the write edge. It then checks lookup, read data and the change pulse 2 ns after the next edge against a behavioural model updated at that edge.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } step_e;

  // Next colour part after a data write at step s.
  function automatic step_e step_after(step_e s);
    case (s)
      STEP_RED: step_after = STEP_GRN;
      STEP_GRN: step_after = STEP_BLU;
      default:  step_after = STEP_RED;
    endcase
  endfunction

  // True when a data write at step s completes an entry.
  function automatic logic is_last_part(step_e s);
    is_last_part = (s == STEP_BLU);
  endfunction

endpackage

// File: rtl/pal_regdec.sv
module pal_regdec #(
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              idx_wr,
  output logic              data_wr
);
  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic wr_cyc;
  assign wr_cyc  = bus_sel && bus_we;
  // full offset compare: unaligned and unused offsets decode to nothing
  assign idx_wr  = wr_cyc && (bus_addr == IDX_A);
  assign data_wr = wr_cyc && (bus_addr == DATA_A);
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] idx_field,
  output logic [IDX_W-1:0] cur_idx,
  output step_e            cur_step,
  output logic             changed
);
  logic [IDX_W-1:0] idx_q;
  step_e            step_q;
  logic             chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= data_wr;
      if (idx_wr) begin
        idx_q  <= idx_field;
        step_q <= STEP_RED;
      end else if (data_wr) begin
        step_q <= step_after(step_q);
        if (is_last_part(step_q))
          idx_q <= idx_q + 1'b1;   // wraps modulo 2**IDX_W
      end
    end
  end

  assign cur_idx  = idx_q;
  assign cur_step = step_q;
  assign changed  = chg_q;
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  step_e               wr_step,
  input  logic [COMP_W-1:0]   wr_val,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [3*COMP_W-1:0] rd_rgb
);
  localparam int NUM_ENT = 1 << IDX_W;
  localparam int RGB_W   = 3 * COMP_W;

  // Replace one colour part of a packed {R,G,B} word.
  function automatic logic [RGB_W-1:0] merge_part(logic [RGB_W-1:0] old,
                                                  step_e s,
                                                  logic [COMP_W-1:0] v);
    logic [RGB_W-1:0] n;
    n = old;
    case (s)
      STEP_RED: n[3*COMP_W-1 -: COMP_W] = v;
      STEP_GRN: n[2*COMP_W-1 -: COMP_W] = v;
      default:  n[COMP_W-1   -: COMP_W] = v;
    endcase
    return n;
  endfunction

  logic [RGB_W-1:0] ent_q [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    localparam logic [RGB_W-1:0] INIT = (e == NUM_ENT-1) ? {RGB_W{1'b1}} : '0;
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[e] <= INIT;
      else if (hit)
        ent_q[e] <= merge_part(ent_q[e], wr_step, wr_val);
    end
  end

  assign rd_rgb = ent_q[rd_idx];
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]    lu_idx,
  output logic [3*COMP_W-1:0] lu_rgb,
  output logic                pal_changed
);
  localparam int TOP_W = (IDX_W > COMP_W) ? IDX_W : COMP_W;

  logic              idx_wr;
  logic              data_wr;
  logic [IDX_W-1:0]  idx_field;
  logic [COMP_W-1:0] comp_field;
  logic [IDX_W-1:0]  cur_idx;
  step_e             cur_step;

  assign idx_field  = bus_wdata[DATA_W-1 -: IDX_W];
  assign comp_field = bus_wdata[DATA_W-1 -: COMP_W];
  logic unused_low;
  assign unused_low = ^bus_wdata[DATA_W-TOP_W-1:0];

  pal_regdec #(.ADDR_W(ADDR_W), .IDX_OFS(0), .DATA_OFS(4)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .idx_wr  (idx_wr),
    .data_wr (data_wr)
  );

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr),
    .idx_field(idx_field),
    .cur_idx  (cur_idx),
    .cur_step (cur_step),
    .changed  (pal_changed)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (data_wr),
    .wr_idx (cur_idx),
    .wr_step(cur_step),
    .wr_val (comp_field),
    .rd_idx (lu_idx),
    .rd_rgb (lu_rgb)
  );

  assign bus_rdata = '0;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              idx_wr,
  input logic              data_wr,
  input logic [IDX_W-1:0]  idx_field,
  input logic [IDX_W-1:0]  cur_idx,
  input step_e             cur_step,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pal_changed
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cur_idx == $past(idx_field)) && (cur_step == STEP_RED));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_step != STEP_BLU) |=>
      (cur_idx == $past(cur_idx)) && (cur_step != $past(cur_step)) && (cur_step != STEP_RED));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_step == STEP_BLU) |=>
      (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_step == STEP_RED));

  a_r4_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> (bus_rdata == '0));

  a_r5_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (cur_idx == '0) && (cur_step == STEP_RED));

  a_r6_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !idx_wr && !data_wr) |=> $stable(cur_idx) && $stable(cur_step));

  a_r8_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> pal_changed);

  a_r8_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !pal_changed);
endmodule

bind pal_dac pal_dac_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .idx_wr     (idx_wr),
  .data_wr    (data_wr),
  .idx_field  (idx_field),
  .cur_idx    (cur_idx),
  .cur_step   (cur_step),
  .bus_rdata  (bus_rdata),
  .pal_changed(pal_changed)
);

// File: tb/tb_pal_dac.sv
`timescale 1ns/1ps
module tb_pal_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lu_idx = '0;
  logic [23:0] lu_rgb;
  logic        pal_changed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  pal_dac dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lu_idx(lu_idx), .lu_rgb(lu_rgb), .pal_changed(pal_changed)
  );

  // behavioural reference model
  int m_red[256], m_grn[256], m_blu[256];
  int m_ptr;
  int m_part;        // 0 red, 1 green, 2 blue
  bit m_chg;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        m_red[i] = (i == 255) ? 255 : 0;
        m_grn[i] = m_red[i];
        m_blu[i] = m_red[i];
      end
      m_ptr = 0; m_part = 0; m_chg = 0;
    end else begin
      m_chg = 0;
      if (bus_sel && bus_we && bus_addr == 4'h0) begin
        m_ptr = bus_wdata >> 24; m_part = 0;
      end else if (bus_sel && bus_we && bus_addr == 4'h4) begin
        m_chg = 1;
        if (m_part == 0) m_red[m_ptr] = bus_wdata >> 24;
        else if (m_part == 1) m_grn[m_ptr] = bus_wdata >> 24;
        else m_blu[m_ptr] = bus_wdata >> 24;
        if (m_part == 2) begin m_part = 0; m_ptr = (m_ptr + 1) % 256; end
        else m_part = m_part + 1;
      end
    end
  end

  function automatic logic [23:0] model_rgb(int i);
    return 24'((m_red[i] << 16) | (m_grn[i] << 8) | m_blu[i]);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive, pre-edge lookup check, post-edge full check
  task automatic cyc(bit sel, bit we, logic [3:0] a, logic [31:0] d, logic [7:0] li);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; lu_idx = li;
    #1;
    check(lu_rgb == model_rgb(li), "R7 old value before edge", {8'h0, lu_rgb}, {8'h0, model_rgb(li)});
    @(posedge clk); #2;
    check(lu_rgb == model_rgb(lu_idx), "R7 lookup", {8'h0, lu_rgb}, {8'h0, model_rgb(lu_idx)});
    check(bus_rdata == 32'h0, "R4 read zero", bus_rdata, 32'h0);
    check(pal_changed == m_chg, "R8 change pulse", {31'h0, pal_changed}, {31'h0, m_chg});
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] top, logic [7:0] li);
    cyc(1, 1, a, {top, 24'h5A3C96}, li);   // junk low bits: R6
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R5: reset contents
    for (int i = 0; i < 256; i++) begin
      cyc(0, 0, 0, 0, 8'(i));
      check(lu_rgb == ((i == 255) ? 24'hFFFFFF : 24'h0), "R5 reset entry",
            {8'h0, lu_rgb}, (i == 255) ? 32'hFFFFFF : 32'h0);
    end
    // R5: pointer 0 after reset -> red of entry 0
    wr(4'h4, 8'h11, 8'h00);
    check(lu_rgb == 24'h110000, "R5 pointer cleared", {8'h0, lu_rgb}, 32'h110000);
    // R1/R2: full entry load
    wr(4'h0, 8'h05, 8'h05);
    wr(4'h4, 8'hA1, 8'h05);
    wr(4'h4, 8'hB2, 8'h05);
    wr(4'h4, 8'hC3, 8'h05);
    check(lu_rgb == 24'hA1B2C3, "R2 entry 5", {8'h0, lu_rgb}, 32'hA1B2C3);
    // R3: auto increment to entry 6
    wr(4'h4, 8'h07, 8'h06);
    check(lu_rgb == 24'h070000, "R3 autoinc", {8'h0, lu_rgb}, 32'h070000);
    // R1: pointer write restarts at red
    wr(4'h0, 8'h0A, 8'h0A);
    wr(4'h4, 8'h22, 8'h0A);
    wr(4'h0, 8'h14, 8'h14);
    wr(4'h4, 8'h33, 8'h14);
    check(lu_rgb == 24'h330000, "R1 restart red", {8'h0, lu_rgb}, 32'h330000);
    // R6: ignored offsets in the middle of a sequence
    wr(4'h8, 8'h99, 8'h14);
    wr(4'hC, 8'h98, 8'h14);
    wr(4'h1, 8'h97, 8'h14);
    wr(4'h5, 8'h96, 8'h14);
    check(lu_rgb == 24'h330000, "R6 ignored offsets", {8'h0, lu_rgb}, 32'h330000);
    wr(4'h4, 8'h44, 8'h14);
    check(lu_rgb == 24'h334400, "R6 sequencer kept", {8'h0, lu_rgb}, 32'h334400);
    // R3: wrap 255 -> 0
    wr(4'h0, 8'hFF, 8'hFF);
    wr(4'h4, 8'h01, 8'hFF);
    wr(4'h4, 8'h02, 8'hFF);
    wr(4'h4, 8'h03, 8'hFF);
    check(lu_rgb == 24'h010203, "R2 entry 255", {8'h0, lu_rgb}, 32'h010203);
    wr(4'h4, 8'h55, 8'h00);
    check(lu_rgb == 24'h550000, "R3 wrap to 0", {8'h0, lu_rgb}, 32'h550000);
    // R4: reads at several offsets
    cyc(1, 0, 4'h0, 0, 8'h05);
    cyc(1, 0, 4'h4, 0, 8'h05);
    cyc(1, 0, 4'h8, 0, 8'h05);
    check(lu_rgb == 24'hA1B2C3, "R4 read no side effect", {8'h0, lu_rgb}, 32'hA1B2C3);
    // R8: idle cycles keep pulse low
    cyc(0, 0, 0, 0, 8'h00);
    check(pal_changed == 1'b0, "R8 pulse low when idle", {31'h0, pal_changed}, 32'h0);
    // burst across several entries
    wr(4'h0, 8'h80, 8'h80);
    for (int k = 0; k < 12; k++) wr(4'h4, 8'(k * 17 + 3), 8'(8'h80 + k / 3));
    cyc(0, 0, 0, 0, 8'h83);
    check(lu_rgb == 24'h9CADBE, "R2 burst entry 0x83", {8'h0, lu_rgb}, 32'h9CADBE);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule